// File: doc/BRIEF.md
# DRAM Idle Low-Power State Controller

This block watches a single bus-idle flag in the DFI clock domain and, as the idle time grows, walks an attached DRAM subsystem through progressively deeper low-power states. There are five states, each with its own idle threshold. Three are self-refresh variants whose thresholds count in blocks of 2^UNIT_SHIFT DFI cycles (1024 by default). The shallow power-down state and the deep standby state count single DFI cycles. All counting is in DFI cycles, which run at half the DRAM clock rate.

The outputs are a power-down request, a self-refresh request, and four clock enables. These cover the controller, the PHY interface, the PHY and the DRAM clock, and a low level means the clock is gated. A 3-bit state code is also provided. Any cycle with the bus busy clears the idle count and starts an orderly wake. The block does not issue DRAM commands and does not train the PHY.

Top module: `dram_idle_lp_ctrl`

## Requirements
- R1: While rst_n is low at a rising edge, the block returns to state code 0 (active), with pd_req and sr_req low and all four clock enables high.
- R2: The idle count clears on every edge that samples bus_idle low and otherwise increments by one. Once the count reaches thr_pd (a non-zero value counted in single cycles), the next edge that samples bus_idle high enters power-down: state code 1, pd_req high.
- R3: Self-refresh (state code 2, sr_req high, pd_req low, all clocks running) is entered once the count reaches thr_sr multiplied by 2^UNIT_SHIFT.
- R4: Self-refresh power-down (state code 3, sr_req and pd_req both high, all clocks running) is entered once the count reaches thr_srpd multiplied by 2^UNIT_SHIFT.
- R5: Self-refresh with controller gating (state code 4) is entered once the count reaches thr_srcg multiplied by 2^UNIT_SHIFT. In this state sr_req is high, ctrl_clk_en is low and the other three enables are high.
- R6: Standby (state code 5) is entered once the count reaches thr_stby in single cycles. In this state sr_req is high and all four clock enables are low.
- R7: A threshold of zero disables its state, so that state is never entered however long the bus stays idle.
- R8: When several thresholds have expired, the state with the highest code wins. The code order is power-down (1) < self-refresh (2) < self-refresh power-down (3) < self-refresh with controller gating (4) < standby (5).
- R9: In any cycle where bus_idle is low, all four clock enables are high in that same cycle. The state then steps down once per edge: codes 4 and 5 go to 2, code 3 goes to 1, and codes 1 and 2 go to 0.
- R10: The idle count saturates at its maximum and does not wrap, so an unbroken idle period never returns the block to a shallower state.
- R11: A single busy cycle restarts the idle count from zero, so thresholds are only met by consecutive idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DFI-domain clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_idle | input | 1 | High while the memory bus has no traffic |
| thr_pd | input | THR_W | Power-down threshold, single cycles |
| thr_sr | input | THR_W | Self-refresh threshold, 2^UNIT_SHIFT-cycle units |
| thr_srpd | input | THR_W | Self-refresh power-down threshold, 2^UNIT_SHIFT-cycle units |
| thr_srcg | input | THR_W | Self-refresh with controller gating threshold, 2^UNIT_SHIFT-cycle units |
| thr_stby | input | THR_W | Standby threshold, single cycles |
| pd_req | output | 1 | Power-down request |
| sr_req | output | 1 | Self-refresh request |
| ctrl_clk_en | output | 1 | Controller clock enable |
| pif_clk_en | output | 1 | PHY-interface clock enable |
| phy_clk_en | output | 1 | PHY clock enable |
| dram_clk_en | output | 1 | DRAM clock enable |
| lp_state | output | 3 | Current state code, 0 to 5 |

## Verification
The bench builds the block with UNIT_SHIFT = 3, CNT_W = 10 and THR_W = 8. With these values one self-refresh unit is 8 cycles, so every one of the five states can be reached within a few hundred idle cycles. Thresholds can also be set so that a coarse state and a fine state expire on the same cycle, which exercises the priority rule. The 10-bit count saturates after 1023 idle cycles, so a run of 1100 idle cycles tests directly that the count does not wrap.

// File: rtl/dram_lp_pkg.sv
// Shared definitions for the DRAM idle low-power controller.
// Assumes the state code order equals depth order; comparisons rely on it.
package dram_lp_pkg;
    localparam int NLVL = 5;

    typedef enum logic [2:0] {
        LP_ACTIVE = 3'd0,
        LP_PDN    = 3'd1,
        LP_SREF   = 3'd2,
        LP_SRPD   = 3'd3,
        LP_SRCG   = 3'd4,
        LP_STBY   = 3'd5
    } lp_state_e;

    // Level index i maps to state code i+1.
    // Levels 1..3 (SR, SRPD, SRCG) count in coarse units.
    localparam logic [NLVL-1:0] COARSE_MASK = 5'b01110;
endpackage

// File: rtl/lp_idle_counter.sv
// Saturating idle counter.
// Counts consecutive cycles with bus_idle high and clears on any busy cycle.
// Holds at all-ones instead of wrapping.
module lp_idle_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_idle,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;

    // Count idle cycles; clear on activity; hold at the ceiling.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!bus_idle)
            cnt_q <= '0;
        else if (cnt_q != CNT_MAX)
            cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;

    // R11
    idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_idle |=> cnt_q == '0);

    // R10
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_idle && cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX);

    // R2
    count_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_idle && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/lp_level_select.sv
// Threshold comparison and depth priority.
// Compares the idle count with each level's limit, where coarse levels are
// scaled by 2^UNIT_SHIFT. A zero threshold never expires. The deepest
// expired level is reported as a state code.
module lp_level_select
    import dram_lp_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int THR_W      = 16,
    parameter int UNIT_SHIFT = 10
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [CNT_W-1:0]           cnt_i,
    input  logic [NLVL-1:0][THR_W-1:0] thr_i,
    output lp_state_e                  deepest_o
);
    localparam int SCL_W = THR_W + UNIT_SHIFT;
    localparam int CMP_W = (CNT_W > SCL_W) ? CNT_W : SCL_W;

    logic [NLVL-1:0] expired;
    logic [CMP_W-1:0] cnt_w;

    assign cnt_w = CMP_W'(cnt_i);

    for (genvar i = 0; i < NLVL; i++) begin : g_lvl
        logic [CMP_W-1:0] lim;
        if (COARSE_MASK[i]) begin : g_coarse
            assign lim = CMP_W'(thr_i[i]) << UNIT_SHIFT;
        end else begin : g_fine
            assign lim = CMP_W'(thr_i[i]);
        end
        assign expired[i] = (thr_i[i] != '0) && (cnt_w >= lim);

        // R8
        deepest_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
            expired[i] |-> (deepest_o >= lp_state_e'(3'(i + 1))));
    end

    // Priority pick: the highest expired level overrides lower ones.
    always_comb begin
        deepest_o = LP_ACTIVE;
        for (int k = 0; k < NLVL; k++) begin
            if (expired[k])
                deepest_o = lp_state_e'(3'(k + 1));
        end
    end

    // R7
    zero_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_i != '0 && expired == '0) |-> deepest_o == LP_ACTIVE);
endmodule

// File: rtl/lp_state_seq.sv
// Low-power state register and output decode.
// Moves up directly to a deeper target. Moves down one step per cycle:
// gating first, then self-refresh, then power-down. While the bus is busy,
// all clock gating is released in the same cycle.
module lp_state_seq
    import dram_lp_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      bus_idle,
    input  lp_state_e deepest_i,
    output lp_state_e state_o,
    output logic      pd_req,
    output logic      sr_req,
    output logic      ctrl_clk_en,
    output logic      pif_clk_en,
    output logic      phy_clk_en,
    output logic      dram_clk_en
);
    lp_state_e cur_q, tgt, step_dn, nxt;

    // Target is forced to active whenever the bus is busy.
    always_comb tgt = bus_idle ? deepest_i : LP_ACTIVE;

    // One exit step: ungate, then leave self-refresh, then leave power-down.
    always_comb begin
        case (cur_q)
            LP_STBY, LP_SRCG: step_dn = LP_SREF;
            LP_SRPD:          step_dn = LP_PDN;
            default:          step_dn = LP_ACTIVE;
        endcase
    end

    // Next state: jump deeper, step shallower, or hold.
    always_comb begin
        if (tgt > cur_q)
            nxt = tgt;
        else if (tgt < cur_q)
            nxt = step_dn;
        else
            nxt = cur_q;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_q <= LP_ACTIVE;
        else
            cur_q <= nxt;
    end

    // Output decode; gating is qualified by bus_idle for immediate wake.
    logic gate_ctrl, gate_all;
    always_comb begin
        pd_req    = (cur_q == LP_PDN) || (cur_q == LP_SRPD);
        sr_req    = (cur_q == LP_SREF) || (cur_q == LP_SRPD) ||
                    (cur_q == LP_SRCG) || (cur_q == LP_STBY);
        gate_ctrl = bus_idle && ((cur_q == LP_SRCG) || (cur_q == LP_STBY));
        gate_all  = bus_idle && (cur_q == LP_STBY);
    end

    assign state_o     = cur_q;
    assign ctrl_clk_en = !gate_ctrl;
    assign pif_clk_en  = !gate_all;
    assign phy_clk_en  = !gate_all;
    assign dram_clk_en = !gate_all;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> cur_q == LP_ACTIVE);

    // R9
    gated_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_idle && (cur_q == LP_STBY || cur_q == LP_SRCG)) |=> cur_q == LP_SREF);

    // R9
    srpd_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_idle && cur_q == LP_SRPD) |=> cur_q == LP_PDN);

    // R5
    gate_needs_sr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_clk_en |-> sr_req);

    // R6
    full_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_clk_en |-> (!ctrl_clk_en && sr_req && !pd_req));
endmodule

// File: rtl/dram_idle_lp_ctrl.sv
// Top level of the DRAM idle low-power state controller.
// Ties the idle counter, the threshold selector and the state sequencer
// together. Assumes thresholds are quasi-static in the DFI clock domain.
module dram_idle_lp_ctrl
    import dram_lp_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int THR_W      = 16,
    parameter int UNIT_SHIFT = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_idle,
    input  logic [THR_W-1:0] thr_pd,
    input  logic [THR_W-1:0] thr_sr,
    input  logic [THR_W-1:0] thr_srpd,
    input  logic [THR_W-1:0] thr_srcg,
    input  logic [THR_W-1:0] thr_stby,
    output logic             pd_req,
    output logic             sr_req,
    output logic             ctrl_clk_en,
    output logic             pif_clk_en,
    output logic             phy_clk_en,
    output logic             dram_clk_en,
    output logic [2:0]       lp_state
);
    logic [CNT_W-1:0]           idle_cnt;
    logic [NLVL-1:0][THR_W-1:0] thr_vec;
    lp_state_e                  deepest, state;

    // Level index order follows the depth order of the state codes.
    assign thr_vec = {thr_stby, thr_srcg, thr_srpd, thr_sr, thr_pd};

    lp_idle_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_idle (bus_idle),
        .cnt_o    (idle_cnt)
    );

    lp_level_select #(
        .CNT_W      (CNT_W),
        .THR_W      (THR_W),
        .UNIT_SHIFT (UNIT_SHIFT)
    ) u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_i     (idle_cnt),
        .thr_i     (thr_vec),
        .deepest_o (deepest)
    );

    lp_state_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_idle    (bus_idle),
        .deepest_i   (deepest),
        .state_o     (state),
        .pd_req      (pd_req),
        .sr_req      (sr_req),
        .ctrl_clk_en (ctrl_clk_en),
        .pif_clk_en  (pif_clk_en),
        .phy_clk_en  (phy_clk_en),
        .dram_clk_en (dram_clk_en)
    );

    assign lp_state = state;

    // R9
    wake_ungate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_idle |-> (ctrl_clk_en && pif_clk_en && phy_clk_en && dram_clk_en));
endmodule

// File: tb/dram_idle_lp_ctrl_bench.sv
`timescale 1ns/1ps
module dram_idle_lp_ctrl_bench;
    localparam int CNT_W  = 10;
    localparam int THR_W  = 8;
    localparam int USHIFT = 3;
    localparam int CMAX   = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_idle = 1'b0;
    logic [THR_W-1:0] thr_pd = '0, thr_sr = '0, thr_srpd = '0, thr_srcg = '0, thr_stby = '0;
    logic pd_req, sr_req, ctrl_clk_en, pif_clk_en, phy_clk_en, dram_clk_en;
    logic [2:0] lp_state;

    always #2.5 clk = ~clk;

    dram_idle_lp_ctrl #(.CNT_W(CNT_W), .THR_W(THR_W), .UNIT_SHIFT(USHIFT)) u_dram_idle_lp_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_idle(bus_idle),
        .thr_pd(thr_pd), .thr_sr(thr_sr), .thr_srpd(thr_srpd),
        .thr_srcg(thr_srcg), .thr_stby(thr_stby),
        .pd_req(pd_req), .sr_req(sr_req), .ctrl_clk_en(ctrl_clk_en),
        .pif_clk_en(pif_clk_en), .phy_clk_en(phy_clk_en),
        .dram_clk_en(dram_clk_en), .lp_state(lp_state)
    );

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;
    string phase = "R1";

    // Reference model state
    int m_cnt = 0;
    int m_state = 0;
    int pend_thr[5] = '{0, 0, 0, 0, 0};   // pd, sr, srpd, srcg, stby
    bit pend_rst = 0;

    function automatic int limit_of(int code, int thr);
        // codes 2..4 count in coarse units
        if (code >= 2 && code <= 4) return thr * (1 << USHIFT);
        return thr;
    endfunction

    task automatic model_edge();
        int want;
        int thr_now[5];
        thr_now = '{int'(thr_pd), int'(thr_sr), int'(thr_srpd), int'(thr_srcg), int'(thr_stby)};
        if (!rst_n) begin
            m_cnt = 0;
            m_state = 0;
        end else begin
            want = 0;
            if (bus_idle)
                foreach (thr_now[j])
                    if (thr_now[j] != 0 && m_cnt >= limit_of(j + 1, thr_now[j]))
                        want = j + 1;
            if (want > m_state)
                m_state = want;
            else if (want < m_state)
                m_state = (m_state >= 4) ? 2 : (m_state == 3) ? 1 : 0;
            if (!bus_idle) m_cnt = 0;
            else if (m_cnt < CMAX) m_cnt = m_cnt + 1;
        end
    endtask

    task automatic chk(string fld, string req, int act, int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s (%s) %s: actual %0d expected %0d at %0t", req, phase, fld, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        bit gc, ga;
        gc = bus_idle && (m_state == 4 || m_state == 5);
        ga = bus_idle && (m_state == 5);
        chk("lp_state", "R8", int'(lp_state), m_state);
        chk("pd_req", "R2", int'(pd_req), (m_state == 1 || m_state == 3) ? 1 : 0);
        chk("sr_req", "R3", int'(sr_req), (m_state >= 2) ? 1 : 0);
        chk("ctrl_clk_en", "R5", int'(ctrl_clk_en), gc ? 0 : 1);
        chk("pif_clk_en", "R6", int'(pif_clk_en), ga ? 0 : 1);
        chk("phy_clk_en", "R6", int'(phy_clk_en), ga ? 0 : 1);
        chk("dram_clk_en", "R9", int'(dram_clk_en), ga ? 0 : 1);
    endtask

    // One cycle: compare at the falling edge, apply inputs, update model at rise.
    task automatic tick(bit idle);
        @(negedge clk);
        compare_all();
        bus_idle = idle;
        rst_n    = !pend_rst;
        thr_pd   = THR_W'(pend_thr[0]);
        thr_sr   = THR_W'(pend_thr[1]);
        thr_srpd = THR_W'(pend_thr[2]);
        thr_srcg = THR_W'(pend_thr[3]);
        thr_stby = THR_W'(pend_thr[4]);
        @(posedge clk);
        model_edge();
    endtask

    task automatic run(bit idle, int n);
        for (int k = 0; k < n; k++) tick(idle);
    endtask

    task automatic set_thr(int a, int b, int c, int d, int e);
        pend_thr = '{a, b, c, d, e};
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        phase = "R1 reset";
        pend_rst = 1;
        @(posedge clk);
        model_edge();
        run(0, 3);
        pend_rst = 0;
        run(1, 2);

        // R2: power-down after 5 idle cycles, then wake
        phase = "R2 power-down";
        set_thr(5, 0, 0, 0, 0);
        run(0, 2);
        run(1, 12);
        run(0, 4);

        // R11: interrupted idle never reaches the threshold
        phase = "R11 restart";
        for (int r = 0; r < 6; r++) begin
            run(1, 4);
            run(0, 1);
        end

        // R3: self-refresh at 4 units (32 cycles)
        phase = "R3 self-refresh";
        set_thr(5, 4, 0, 0, 0);
        run(0, 1);
        run(1, 45);
        run(0, 3);

        // R4: self-refresh power-down, exit steps through power-down
        phase = "R4 sr power-down";
        set_thr(3, 0, 6, 0, 0);
        run(0, 1);
        run(1, 60);
        run(0, 4);

        // R5: controller clock gating
        phase = "R5 sr ctrl gate";
        set_thr(2, 1, 0, 8, 0);
        run(0, 1);
        run(1, 80);
        run(0, 4);

        // R6: standby in single-cycle units
        phase = "R6 standby";
        set_thr(2, 1, 3, 5, 100);
        run(0, 1);
        run(1, 120);
        run(0, 4);

        // R7: all thresholds zero keep the block active
        phase = "R7 zero disables";
        set_thr(0, 0, 0, 0, 0);
        run(1, 300);
        set_thr(4, 0, 0, 0, 0);
        run(0, 1);
        run(1, 200);
        run(0, 2);

        // R8: coincident expiry, deepest wins
        phase = "R8 priority";
        set_thr(3, 1, 2, 1, 20);
        run(0, 1);
        run(1, 40);
        run(0, 1);

        // R9: brief wake from standby, then idle again mid-exit
        phase = "R9 wake";
        set_thr(2, 0, 0, 0, 10);
        run(0, 1);
        run(1, 20);
        run(0, 1);
        run(1, 1);
        run(1, 15);
        run(0, 1);
        run(1, 2);
        run(0, 3);

        // R10: long idle past counter saturation stays in self-refresh
        phase = "R10 saturation";
        set_thr(0, 2, 0, 0, 0);
        run(0, 1);
        run(1, 1100);
        run(0, 3);

        tick(0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule